// File: doc/BRIEF.md
# Interrupt Request Latch with Per-Line Trigger Select

This block turns a set of raw interrupt input lines into a request register that priority logic can read. Each line has its own trigger-mode bit. In level mode the request bit follows the input. In edge mode a rising input sets the request bit, and only an acknowledge clears it. The block keeps the previous level of every line so that it can detect rising inputs.

An acknowledge names one line by index and clears that line's request only when the line is edge-triggered. Writes to the trigger-mode register pass through a fixed writable-bit mask that is a parameter of the instance. The master controller uses 0xF8 and the slave uses 0xDE, so some lines can never be set to level mode. For every sample the block also reports two things per line: whether a capture event found the request bit clear, or whether the event landed on a masked line.

Top module: `irq_req_latch`

## Requirements
- R1: While reset (`rst_n` low) is asserted, and after it, the request register, the stored previous levels, the trigger-mode register, `newRaise` and `maskedHit` are all zero. Zero trigger-mode bits mean that every line is edge-triggered.
- R2: A line whose trigger-mode bit is 1 (level mode) has its request bit equal to its input as sampled at the previous rising clock edge. It is set while the input is high and cleared when the input is low.
- R3: A line whose trigger-mode bit is 0 (edge mode) gets its request bit set when the sampled input is high and the stored previous level is low. A high input that was already high, or a falling input, leaves the bit unchanged.
- R4: The stored previous level of every line is updated at every clock edge, in both modes. A line switched from level to edge mode while its input is high therefore does not see a new rising edge.
- R5: When `ackValid` is high, request bit `ackIdx` is cleared at the clock edge if that line is in edge mode. If the line is in level mode the acknowledge has no effect.
- R6: If a rising edge on an edge-mode line is sampled at the same edge as an acknowledge of that line, the request bit stays set.
- R7: When `trigWrEn` is high, the trigger-mode register takes `trigWrData & WR_MASK` at the clock edge. `WR_MASK` is 0xF8 for the master (the default) and 0xDE for the slave. With no write, the register holds its value.
- R8: A capture event is an edge-mode rising edge or a level-mode high input. At the edge after a sample, `newRaise[n]` is 1 exactly when line n had a capture event, its request bit was clear before that edge, and `maskIn[n]` was 0.
- R9: At the edge after a sample, `maskedHit[n]` is 1 exactly when line n had a capture event and `maskIn[n]` was 1. In that case `newRaise[n]` is 0, and the request bit is still captured.
- R10: All outputs are registered and change one edge after the inputs are sampled. A trigger-mode write governs capture from the following sample onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lineIn | input | LINES | Raw interrupt input levels |
| maskIn | input | LINES | Mask register, 1 = masked |
| ackValid | input | 1 | Acknowledge strobe |
| ackIdx | input | IDX_W | Index of the acknowledged line |
| trigWrEn | input | 1 | Trigger-mode register write strobe |
| trigWrData | input | LINES | Trigger-mode write data, 1 = level |
| reqReg | output | LINES | Interrupt request register |
| trigMode | output | LINES | Trigger-mode register contents |
| newRaise | output | LINES | Capture event found the request clear on an unmasked line |
| maskedHit | output | LINES | Capture event on a masked line |

## Verification
Every output of this block is a register, so each result is due exactly one rising edge after the inputs that cause it are sampled. A trigger-mode write changes capture behaviour only from the sample after that edge. The driver stamps each expected item with the cycle count at which it is due. The monitor pops an item only when the cycle counter reaches that stamp, and it compares on the falling edge, when the outputs are stable. Mode switches with the input held high, and acknowledges that coincide with edges, are placed so that the one-edge latency separates correct and off-by-one behaviour.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;
  typedef struct packed {
    logic ackStb;
    logic trigWr;
  } latchStrobes_t;
endpackage

// File: rtl/irq_latch_ctrl.sv
module irq_latch_ctrl
  import irq_latch_pkg::*;
#(
  parameter int LINES = 8,
  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic             ackValid,
  input  logic [IDX_W-1:0] ackIdx,
  input  logic             trigWrEn,
  output logic [LINES-1:0] ackSel,
  output latchStrobes_t    strb
);
  always_comb begin
    ackSel = '0;
    for (int i = 0; i < LINES; i++) begin
      if (ackValid && (ackIdx == IDX_W'(i))) ackSel[i] = 1'b1;
    end
    strb.ackStb = ackValid;
    strb.trigWr = trigWrEn;
  end

  always_comb begin
    assert ($onehot0(ackSel)) else $error("AST_ACK_ONEHOT"); // R5
  end
endmodule

// File: rtl/irq_latch_dp.sv
module irq_latch_dp
  import irq_latch_pkg::*;
#(
  parameter int LINES = 8,
  parameter logic [LINES-1:0] WR_MASK = 8'hF8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] lineIn,
  input  logic [LINES-1:0] maskIn,
  input  logic [LINES-1:0] ackSel,
  input  latchStrobes_t    strb,
  input  logic [LINES-1:0] trigWrData,
  output logic [LINES-1:0] reqReg,
  output logic [LINES-1:0] trigMode,
  output logic [LINES-1:0] newRaise,
  output logic [LINES-1:0] maskedHit
);
  logic [LINES-1:0] prevLvl;
  logic [LINES-1:0] setEvt;
  logic [LINES-1:0] reqNext;

  for (genvar n = 0; n < LINES; n++) begin : g_line
    always_comb begin
      if (trigMode[n]) begin
        setEvt[n]  = lineIn[n];
        reqNext[n] = lineIn[n];
      end else begin
        setEvt[n]  = lineIn[n] & ~prevLvl[n];
        reqNext[n] = setEvt[n] | (reqReg[n] & ~(strb.ackStb & ackSel[n]));
      end
    end

    AST_LEVEL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      trigMode[n] |=> reqReg[n] == $past(lineIn[n])) else $error("AST_LEVEL_FOLLOWS"); // R2
    AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (!trigMode[n] && lineIn[n] && !prevLvl[n]) |=> reqReg[n]) else $error("AST_EDGE_SETS"); // R6
    AST_EDGE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!trigMode[n] && reqReg[n] && !ackSel[n]) |=> reqReg[n]) else $error("AST_EDGE_HOLDS"); // R3
    AST_LEVEL_ACK_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (trigMode[n] && ackSel[n] && lineIn[n]) |=> reqReg[n]) else $error("AST_LEVEL_ACK_IGNORED"); // R5
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reqReg    <= '0;
      prevLvl   <= '0;
      trigMode  <= '0;
      newRaise  <= '0;
      maskedHit <= '0;
    end else begin
      reqReg    <= reqNext;
      prevLvl   <= lineIn;
      newRaise  <= setEvt & ~reqReg & ~maskIn;
      maskedHit <= setEvt & maskIn;
      if (strb.trigWr) trigMode <= trigWrData & WR_MASK;
    end
  end

  AST_TRIG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    strb.trigWr |=> trigMode == ($past(trigWrData) & WR_MASK)) else $error("AST_TRIG_WRITE"); // R7
  AST_TRIG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.trigWr |=> $stable(trigMode)) else $error("AST_TRIG_HOLD"); // R7
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    (newRaise & maskedHit) == '0) else $error("AST_FLAGS_EXCL"); // R9
  AST_PREV_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> prevLvl == $past(lineIn)) else $error("AST_PREV_TRACKS"); // R4
endmodule

// File: rtl/irq_req_latch.sv
module irq_req_latch
  import irq_latch_pkg::*;
#(
  parameter int LINES = 8,
  parameter logic [LINES-1:0] WR_MASK = 8'hF8,
  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] lineIn,
  input  logic [LINES-1:0] maskIn,
  input  logic             ackValid,
  input  logic [IDX_W-1:0] ackIdx,
  input  logic             trigWrEn,
  input  logic [LINES-1:0] trigWrData,
  output logic [LINES-1:0] reqReg,
  output logic [LINES-1:0] trigMode,
  output logic [LINES-1:0] newRaise,
  output logic [LINES-1:0] maskedHit
);
  logic [LINES-1:0] ackSel;
  latchStrobes_t    strb;

  irq_latch_ctrl #(.LINES(LINES)) ctrl_i (
    .ackValid (ackValid),
    .ackIdx   (ackIdx),
    .trigWrEn (trigWrEn),
    .ackSel   (ackSel),
    .strb     (strb)
  );

  irq_latch_dp #(.LINES(LINES), .WR_MASK(WR_MASK)) dp_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .lineIn     (lineIn),
    .maskIn     (maskIn),
    .ackSel     (ackSel),
    .strb       (strb),
    .trigWrData (trigWrData),
    .reqReg     (reqReg),
    .trigMode   (trigMode),
    .newRaise   (newRaise),
    .maskedHit  (maskedHit)
  );
endmodule

// File: tb/irq_req_latch_tb_top.sv
module irq_req_latch_tb_top;
  localparam logic [7:0] MWM = 8'hF8;
  localparam logic [7:0] SWM = 8'hDE;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] lineIn = '0, maskIn = '0, trigWrData = '0;
  logic ackValid = 1'b0, trigWrEn = 1'b0;
  logic [2:0] ackIdx = '0;
  logic [7:0] reqReg, trigMode, newRaise, maskedHit;
  logic sWrEn = 1'b0;
  logic [7:0] sReq, sTrig, sNr, sMh;

  int cyc = 0;
  int nVec = 0;
  int nFail = 0;

  typedef struct {
    int due;
    logic [7:0] req, nr, mh, trig;
    string tag;
  } expItem_t;
  expItem_t expQ[$];

  logic [7:0] mReq = '0, mPrev = '0, mTrig = '0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  irq_req_latch dut_i (
    .clk(clk), .rst_n(rst_n), .lineIn(lineIn), .maskIn(maskIn),
    .ackValid(ackValid), .ackIdx(ackIdx), .trigWrEn(trigWrEn),
    .trigWrData(trigWrData), .reqReg(reqReg), .trigMode(trigMode),
    .newRaise(newRaise), .maskedHit(maskedHit)
  );

  irq_req_latch #(.WR_MASK(SWM)) dut_slave_i (
    .clk(clk), .rst_n(rst_n), .lineIn(8'h00), .maskIn(8'h00),
    .ackValid(1'b0), .ackIdx(3'd0), .trigWrEn(sWrEn),
    .trigWrData(8'hFF), .reqReg(sReq), .trigMode(sTrig),
    .newRaise(sNr), .maskedHit(sMh)
  );

  task automatic cmp(string tag, string what, logic [7:0] act, logic [7:0] exp);
    nVec++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s actual=%02h expected=%02h", tag, what, act, exp);
    end
  endtask

  // driver: applies one sample at a falling edge and queues the expected result
  task automatic step(logic [7:0] lines, logic ackV, logic [2:0] ackI,
                      logic [7:0] msk, logic wr, logic [7:0] wd, string tag);
    expItem_t it;
    logic [7:0] setC, nReq;
    @(negedge clk);
    lineIn = lines; ackValid = ackV; ackIdx = ackI;
    maskIn = msk; trigWrEn = wr; trigWrData = wd;
    for (int n = 0; n < 8; n++) begin
      if (mTrig[n]) begin
        setC[n] = lines[n];
        nReq[n] = lines[n];
      end else begin
        setC[n] = lines[n] & ~mPrev[n];
        nReq[n] = setC[n] | (mReq[n] & ~(ackV && ackI == 3'(n)));
      end
    end
    it.due  = cyc + 1;
    it.nr   = setC & ~mReq & ~msk;
    it.mh   = setC & msk;
    it.req  = nReq;
    if (wr) mTrig = wd & MWM;
    it.trig = mTrig;
    it.tag  = tag;
    mReq  = nReq;
    mPrev = lines;
    expQ.push_back(it);
  endtask

  // monitor: compares results once they are due
  initial begin
    forever begin
      @(negedge clk);
      if (expQ.size() > 0 && expQ[0].due == cyc) begin
        expItem_t it;
        it = expQ.pop_front();
        cmp(it.tag, "reqReg", reqReg, it.req);
        cmp(it.tag, "newRaise", newRaise, it.nr);
        cmp(it.tag, "maskedHit", maskedHit, it.mh);
        cmp(it.tag, "trigMode", trigMode, it.trig);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", nVec, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    cmp("R1", "reqReg in reset", reqReg, 8'h00);
    cmp("R1", "trigMode in reset", trigMode, 8'h00);
    cmp("R1", "newRaise in reset", newRaise, 8'h00);
    cmp("R1", "maskedHit in reset", maskedHit, 8'h00);
    rst_n = 1'b1;
    step(8'h01, 0, 0, 8'h00, 0, 0, "R3 R8 rise line0");
    step(8'h01, 0, 0, 8'h00, 0, 0, "R3 held high");
    step(8'h00, 0, 0, 8'h00, 0, 0, "R3 fall keeps");
    step(8'h00, 1, 0, 8'h00, 0, 0, "R5 ack edge");
    step(8'h02, 0, 0, 8'h02, 0, 0, "R9 masked rise");
    step(8'h00, 0, 0, 8'h00, 1, 8'hFF, "R7 trig write master");
    step(8'h08, 0, 0, 8'h00, 0, 0, "R2 R10 level high");
    step(8'h08, 1, 3, 8'h00, 0, 0, "R5 ack level ignored");
    step(8'h00, 0, 0, 8'h00, 0, 0, "R2 level low clears");
    step(8'h10, 0, 0, 8'h00, 0, 0, "R2 level line4");
    step(8'h10, 0, 0, 8'h00, 1, 8'h00, "R4 R10 switch to edge");
    step(8'h10, 0, 0, 8'h00, 0, 0, "R4 no new edge");
    step(8'h10, 1, 4, 8'h00, 0, 0, "R4 ack after switch");
    step(8'h01, 0, 0, 8'h00, 0, 0, "R3 rise line0 again");
    step(8'h00, 0, 0, 8'h00, 0, 0, "R3 fall");
    step(8'h01, 1, 0, 8'h00, 0, 0, "R6 edge beats ack");
    step(8'h00, 1, 1, 8'h00, 0, 0, "R5 ack line1");
    step(8'h00, 1, 0, 8'h00, 0, 0, "R5 ack line0");
    step(8'h00, 0, 0, 8'h00, 1, 8'h28, "R7 partial write");
    step(8'h2A, 0, 0, 8'h20, 0, 0, "R9 masked level");
    for (int k = 0; k < 300; k++) begin
      step(8'($urandom), 1'($urandom), 3'($urandom), 8'($urandom & 32'h99),
           (($urandom % 8) == 0), 8'($urandom), "R10 random");
    end
    @(negedge clk);
    sWrEn = 1'b1;
    @(negedge clk);
    sWrEn = 1'b0;
    cmp("R7", "slave trigMode", sTrig, SWM);
    repeat (3) @(negedge clk);
    if (expQ.size() != 0) begin
      nFail++;
      $display("FAIL R10 %0d results never compared, expected 0", expQ.size());
    end
    $display("  == %0d vectors applied, %0d miscompares ==", nVec, nFail);
    $finish;
  end
endmodule